// File: doc/BRIEF.md
# SDRAM Mode Register Programming Sequencer

This block sits on the controller side of a DDR-style SDRAM. It writes the two mode registers of the memory in the order the memory needs. A single-cycle `start` request begins the sequence. The block first checks that no bank is open, then checks that the requested settings are supported. If both checks pass, it issues a precharge-all command and waits the row-precharge time. It then writes the extended mode register, waits the mode-register-set delay, writes the main mode register and waits that delay again.

The burst length, burst type, read latency and DLL-reset request are sampled together with `start`. Changes on those inputs after that point do not affect the current sequence. If any bank is open, or if the settings are not supported, the block raises a one-cycle flag and sends no command. During reset the command pins are held in deselect. Outside reset, every cycle that carries no command drives NOP.

Top module: `mrs_sequencer`

## Requirements
- R1: While reset is asserted, `csN`, `rasN`, `casN` and `weN` are all 1 (deselect), `addr` and `bankAddr` are zero, and `busy`, `done`, `illegalReq` and `cfgError` are 0.
- R2: After reset, every cycle without a command drives NOP: `csN`=0, `rasN`=`casN`=`weN`=1, with `addr` and `bankAddr` at zero.
- R3: If `start` is sampled while `busy` is low and any bit of `bankActive` is 1, then `illegalReq` is 1 in the following cycle, no command is issued, and `busy` stays low. This check takes priority over the settings check.
- R4: If `start` is sampled while `busy` is low, all banks are idle, and the settings are not supported, then `cfgError` is 1 in the following cycle and no command is issued. Supported burst length codes are 001, 010 and 011; code 111 is also supported, but only with sequential burst type. Supported read latency codes are 010 and 011; code 110 is also supported when HALF_CL_EN is set.
- R5: An accepted start produces a precharge-all command in the next cycle (`csN`=0, `rasN`=0, `casN`=1, `weN`=0, address bit 10 = 1, all other address bits 0). `busy` rises in that same cycle.
- R6: Exactly T_RP cycles after the precharge cycle, the block writes the extended register: all four command pins 0, `bankAddr`=01, `addr`=0. Only NOPs appear in between.
- R7: Exactly T_MRD cycles after the extended write, the block writes the main register with `bankAddr`=00 and an address word laid out as follows: bits 2:0 hold the burst length code, bit 3 the burst type (1 = interleave), bits 6:4 the read latency code, bit 7 is 0, bit 8 holds the DLL-reset request, and all higher bits are 0. Only NOPs appear in between.
- R8: After the main write, the block drives T_MRD-1 NOP cycles with `busy` high. In the next cycle `busy` is low and `done` is 1, for that one cycle only.
- R9: While `busy` is high, `start` is ignored. The word written to the main register is the one built from the inputs sampled with the accepted start.
- R10: Burst length code 111 with sequential burst type is accepted, and the full sequence is carried out.
- R11: With HALF_CL_EN=1, read latency code 110 is accepted and is written to bits 6:4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to run the programming sequence |
| bankActive | input | NUM_BANKS | One bit per bank; 1 means the bank is open |
| burstLenSel | input | 3 | Burst length code |
| burstInterleave | input | 1 | Burst type: 1 = interleave, 0 = sequential |
| readLatSel | input | 3 | Read latency code |
| dllReset | input | 1 | Request a DLL reset in the main register word |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address bus |
| bankAddr | output | BA_W | Bank address bus |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the sequence has finished |
| illegalReq | output | 1 | One-cycle flag: start arrived while a bank was open |
| cfgError | output | 1 | One-cycle flag: start arrived with unsupported settings |

## Verification
All results are timed from the clock edge that samples `start`. `illegalReq` or `cfgError` appears one cycle after that edge. The precharge appears one cycle after it. The extended write follows T_RP cycles after the precharge, the main write T_MRD cycles after that, and `done` T_MRD cycles after the main write. The bench's reference model counts cycles from the accepted start and uses that count to predict every pin for every cycle. The outputs are compared on each falling clock edge, half a period after the rising edge that updates the registered pins. Directed runs then compare the word written to the main register against a word built independently from the inputs of the accepted request. These runs include the case where the inputs change, and the case where `start` is pulsed again, while the block is busy.

// File: rtl/mrs_pkg.sv
package mrs_pkg;

  // Command pin order: {csN, rasN, casN, weN}
  localparam logic [3:0] PINS_DESEL = 4'b1111;
  localparam logic [3:0] PINS_NOP   = 4'b0111;
  localparam logic [3:0] PINS_PRE   = 4'b0010;
  localparam logic [3:0] PINS_MRS   = 4'b0000;

  // Bit positions in the main register word (the memory decodes these)
  localparam int BL_LSB  = 0;
  localparam int BT_BIT  = 3;
  localparam int CL_LSB  = 4;
  localparam int TM_BIT  = 7;
  localparam int DLL_BIT = 8;
  localparam int AP_BIT  = 10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT_RP,
    ST_WAIT_EXT,
    ST_WAIT_MAIN
  } seqState_t;

  typedef struct packed {
    logic capture;
    logic issuePre;
    logic issueExt;
    logic issueMain;
    logic busyNext;
    logic doneNext;
    logic illegalNext;
    logic cfgErrNext;
  } seqStrobe_t;

  function automatic logic burstCodeOk(input logic [2:0] code, input logic interleave);
    case (code)
      3'b001, 3'b010, 3'b011: burstCodeOk = 1'b1;
      3'b111:                 burstCodeOk = !interleave;
      default:                burstCodeOk = 1'b0;
    endcase
  endfunction

  function automatic logic latencyCodeOk(input logic [2:0] code, input logic halfAllowed);
    case (code)
      3'b010, 3'b011: latencyCodeOk = 1'b1;
      3'b110:         latencyCodeOk = halfAllowed;
      default:        latencyCodeOk = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mrs_control.sv
module mrs_control
  import mrs_pkg::*;
#(
  parameter int T_RP  = 3,
  parameter int T_MRD = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       anyBankActive,
  input  logic       cfgOk,
  output seqStrobe_t strobe
);

  localparam int MAX_WAIT = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int CNT_W    = (MAX_WAIT > 1) ? $clog2(MAX_WAIT) : 1;
  localparam logic [CNT_W-1:0] RP_LOAD  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] MRD_LOAD = CNT_W'(T_MRD - 1);

  seqState_t        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             cntZero;

  assign cntZero = (cnt == '0);

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextCnt   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (anyBankActive) begin
            strobe.illegalNext = 1'b1;
          end else if (!cfgOk) begin
            strobe.cfgErrNext = 1'b1;
          end else begin
            strobe.capture  = 1'b1;
            strobe.issuePre = 1'b1;
            strobe.busyNext = 1'b1;
            nextCnt         = RP_LOAD;
            nextState       = ST_WAIT_RP;
          end
        end
      end
      ST_WAIT_RP: begin
        strobe.busyNext = 1'b1;
        if (cntZero) begin
          strobe.issueExt = 1'b1;
          nextCnt         = MRD_LOAD;
          nextState       = ST_WAIT_EXT;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      ST_WAIT_EXT: begin
        strobe.busyNext = 1'b1;
        if (cntZero) begin
          strobe.issueMain = 1'b1;
          nextCnt          = MRD_LOAD;
          nextState        = ST_WAIT_MAIN;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      ST_WAIT_MAIN: begin
        if (cntZero) begin
          strobe.doneNext = 1'b1;
          nextState       = ST_IDLE;
        end else begin
          strobe.busyNext = 1'b1;
          nextCnt         = cnt - 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

endmodule

// File: rtl/mrs_datapath.sv
module mrs_datapath
  import mrs_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BA_W       = 2,
  parameter int NUM_BANKS  = 4,
  parameter bit HALF_CL_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [NUM_BANKS-1:0] bankActive,
  input  logic [2:0]           burstLenSel,
  input  logic                 burstInterleave,
  input  logic [2:0]           readLatSel,
  input  logic                 dllReset,
  output logic                 anyBankActive,
  output logic                 cfgOk,
  output logic                 csN,
  output logic                 rasN,
  output logic                 casN,
  output logic                 weN,
  output logic [ADDR_W-1:0]    addr,
  output logic [BA_W-1:0]      bankAddr,
  output logic                 busy,
  output logic                 done,
  output logic                 illegalReq,
  output logic                 cfgError
);

  localparam logic [BA_W-1:0]   SEL_MAIN = '0;
  localparam logic [BA_W-1:0]   SEL_EXT  = BA_W'(1);
  localparam logic [ADDR_W-1:0] EXT_WORD = '0;

  logic [3:0]        cmdQ;
  logic [ADDR_W-1:0] preAddr;
  logic [ADDR_W-1:0] modeNext;
  logic [ADDR_W-1:0] modeWord;
  logic              latOk;
  logic              burstOk;

  assign anyBankActive = |bankActive;

  // Variant choice for the half-step latency code
  generate
    if (HALF_CL_EN) begin : gen_half_cl
      assign latOk = latencyCodeOk(readLatSel, 1'b1);
    end else begin : gen_whole_cl
      assign latOk = latencyCodeOk(readLatSel, 1'b0);
    end
  endgenerate

  assign burstOk = burstCodeOk(burstLenSel, burstInterleave);
  assign cfgOk   = burstOk && latOk;

  // Precharge-all address: only the all-banks bit is set
  generate
    if (ADDR_W > AP_BIT) begin : gen_ap_bit
      assign preAddr = ADDR_W'(1) << AP_BIT;
    end else begin : gen_no_ap_bit
      assign preAddr = '0;
    end
  endgenerate

  always_comb begin
    modeNext                          = '0;
    modeNext[BL_LSB +: 3]             = burstLenSel;
    modeNext[BT_BIT]                  = burstInterleave;
    modeNext[CL_LSB +: 3]             = readLatSel;
    modeNext[TM_BIT]                  = 1'b0;
    modeNext[DLL_BIT]                 = dllReset;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeWord <= '0;
    end else if (strobe.capture) begin
      modeWord <= modeNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdQ       <= PINS_DESEL;
      addr       <= '0;
      bankAddr   <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      illegalReq <= 1'b0;
      cfgError   <= 1'b0;
    end else begin
      cmdQ       <= PINS_NOP;
      addr       <= '0;
      bankAddr   <= '0;
      busy       <= strobe.busyNext;
      done       <= strobe.doneNext;
      illegalReq <= strobe.illegalNext;
      cfgError   <= strobe.cfgErrNext;
      if (strobe.issuePre) begin
        cmdQ <= PINS_PRE;
        addr <= preAddr;
      end else if (strobe.issueExt) begin
        cmdQ     <= PINS_MRS;
        addr     <= EXT_WORD;
        bankAddr <= SEL_EXT;
      end else if (strobe.issueMain) begin
        cmdQ     <= PINS_MRS;
        addr     <= modeWord;
        bankAddr <= SEL_MAIN;
      end
    end
  end

  assign {csN, rasN, casN, weN} = cmdQ;

endmodule

// File: rtl/mrs_sequencer.sv
module mrs_sequencer
  import mrs_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BA_W       = 2,
  parameter int NUM_BANKS  = 4,
  parameter int T_RP       = 3,
  parameter int T_MRD      = 2,
  parameter bit HALF_CL_EN = 1'b1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [NUM_BANKS-1:0] bankActive,
  input  logic [2:0]           burstLenSel,
  input  logic                 burstInterleave,
  input  logic [2:0]           readLatSel,
  input  logic                 dllReset,
  output logic                 csN,
  output logic                 rasN,
  output logic                 casN,
  output logic                 weN,
  output logic [ADDR_W-1:0]    addr,
  output logic [BA_W-1:0]      bankAddr,
  output logic                 busy,
  output logic                 done,
  output logic                 illegalReq,
  output logic                 cfgError
);

  seqStrobe_t strobe;
  logic       anyBankActive;
  logic       cfgOk;

  mrs_control #(
    .T_RP (T_RP),
    .T_MRD(T_MRD)
  ) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .anyBankActive(anyBankActive),
    .cfgOk        (cfgOk),
    .strobe       (strobe)
  );

  mrs_datapath #(
    .ADDR_W    (ADDR_W),
    .BA_W      (BA_W),
    .NUM_BANKS (NUM_BANKS),
    .HALF_CL_EN(HALF_CL_EN)
  ) u_datapath (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .bankActive     (bankActive),
    .burstLenSel    (burstLenSel),
    .burstInterleave(burstInterleave),
    .readLatSel     (readLatSel),
    .dllReset       (dllReset),
    .anyBankActive  (anyBankActive),
    .cfgOk          (cfgOk),
    .csN            (csN),
    .rasN           (rasN),
    .casN           (casN),
    .weN            (weN),
    .addr           (addr),
    .bankAddr       (bankAddr),
    .busy           (busy),
    .done           (done),
    .illegalReq     (illegalReq),
    .cfgError       (cfgError)
  );

endmodule

// File: rtl/mrs_sequencer_checker.sv
module mrs_sequencer_checker #(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2,
  parameter int T_RP   = 3,
  parameter int T_MRD  = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [ADDR_W-1:0] addr,
  input logic [BA_W-1:0]   bankAddr,
  input logic              busy,
  input logic              done,
  input logic              illegalReq,
  input logic              cfgError
);

  logic [3:0]  pins;
  logic        isNop, isPre, isMrs;
  logic        seenEdge;
  logic [15:0] sincePre, sinceMrs;

  assign pins  = {csN, rasN, casN, weN};
  assign isNop = (pins == 4'b0111);
  assign isPre = (pins == 4'b0010);
  assign isMrs = (pins == 4'b0000);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenEdge <= 1'b0;
      sincePre <= '1;
      sinceMrs <= '1;
    end else begin
      seenEdge <= 1'b1;
      if (isPre) sincePre <= 16'd1;
      else if (sincePre != '1) sincePre <= sincePre + 16'd1;
      if (isMrs) sinceMrs <= 16'd1;
      else if (sinceMrs != '1) sinceMrs <= sinceMrs + 16'd1;
    end
  end

  p_selected_after_reset_r2: assert property (@(posedge clk) disable iff (!rstN)
    seenEdge |-> !csN);

  p_illegal_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    illegalReq |-> (!busy && isNop));

  p_illegal_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && illegalReq) |-> $past(start));

  p_cfg_err_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    cfgError |-> (!busy && isNop && !illegalReq));

  p_pre_on_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (isPre && addr[10]));

  p_trp_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    isMrs |-> (busy && sincePre >= 16'(T_RP)));

  p_tmrd_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!isNop && seenEdge) |-> (sinceMrs >= 16'(T_MRD)));

  p_mrs_fields_r7: assert property (@(posedge clk) disable iff (!rstN)
    isMrs |-> (!addr[7] && bankAddr[BA_W-1:1] == '0));

  p_done_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    (seenEdge && done) |-> (!busy && $past(busy)));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind mrs_sequencer mrs_sequencer_checker #(
  .ADDR_W(ADDR_W),
  .BA_W  (BA_W),
  .T_RP  (T_RP),
  .T_MRD (T_MRD)
) u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .csN       (csN),
  .rasN      (rasN),
  .casN      (casN),
  .weN       (weN),
  .addr      (addr),
  .bankAddr  (bankAddr),
  .busy      (busy),
  .done      (done),
  .illegalReq(illegalReq),
  .cfgError  (cfgError)
);

// File: tb/mrs_sequencer_bench.sv
module mrs_sequencer_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int BA_W = 2;
  localparam int NUM_BANKS = 4;
  localparam int T_RP = 3;
  localparam int T_MRD = 2;
  localparam int TOTAL = T_RP + 2 * T_MRD;
  localparam int WATCHDOG = 100000;

  logic                 clk = 1'b0;
  logic                 rstN;
  logic                 start = 1'b0;
  logic [NUM_BANKS-1:0] bankActive = '0;
  logic [2:0]           burstLenSel = 3'b010;
  logic                 burstInterleave = 1'b0;
  logic [2:0]           readLatSel = 3'b010;
  logic                 dllReset = 1'b0;
  logic csN, rasN, casN, weN, busy, done, illegalReq, cfgError;
  logic [ADDR_W-1:0] addr;
  logic [BA_W-1:0]   bankAddr;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  mrs_sequencer #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .NUM_BANKS(NUM_BANKS),
    .T_RP(T_RP), .T_MRD(T_MRD), .HALF_CL_EN(1'b1)
  ) u_mrs_sequencer (
    .clk(clk), .rstN(rstN), .start(start), .bankActive(bankActive),
    .burstLenSel(burstLenSel), .burstInterleave(burstInterleave),
    .readLatSel(readLatSel), .dllReset(dllReset),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .addr(addr), .bankAddr(bankAddr), .busy(busy), .done(done),
    .illegalReq(illegalReq), .cfgError(cfgError)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic bit refValid(input logic [2:0] bl, input logic bt, input logic [2:0] cl);
    bit blOk, clOk;
    blOk = (bl == 3'd1) || (bl == 3'd2) || (bl == 3'd3) || (bl == 3'd7 && bt == 1'b0);
    clOk = (cl == 3'd2) || (cl == 3'd3) || (cl == 3'd6);
    return blOk && clOk;
  endfunction

  function automatic logic [ADDR_W-1:0] refWord(input logic [2:0] bl, input logic bt,
                                                input logic [2:0] cl, input logic dll);
    int w;
    w = bl + bt * 8 + cl * 16 + dll * 256;
    return ADDR_W'(w);
  endfunction

  // Reference model: cycle count since the accepted start
  int                t = -1;
  bit                inReset = 1;
  logic [ADDR_W-1:0] capWord = '0;
  logic [3:0]        expCmd;
  logic [ADDR_W-1:0] expAddr;
  logic [BA_W-1:0]   expBa;
  logic              expBusy, expDone;
  logic              expIll = 1'b0, expErr = 1'b0;
  string             expTag;

  always @(posedge clk) begin
    if (!rstN) begin
      inReset = 1; t = -1; expIll = 0; expErr = 0;
    end else begin
      inReset = 0; expIll = 0; expErr = 0;
      if (t >= 0 && t < TOTAL) begin
        t = t + 1;
      end else begin
        t = -1;
        if (start) begin
          if (bankActive != '0) expIll = 1;
          else if (!refValid(burstLenSel, burstInterleave, readLatSel)) expErr = 1;
          else begin
            t = 0;
            capWord = refWord(burstLenSel, burstInterleave, readLatSel, dllReset);
          end
        end
      end
    end
  end

  always_comb begin
    expCmd = 4'b0111; expAddr = '0; expBa = '0; expBusy = 0; expDone = 0; expTag = "R2";
    if (inReset) begin
      expCmd = 4'b1111; expTag = "R1";
    end else begin
      if (t >= 0 && t < TOTAL) expBusy = 1;
      if (t == TOTAL) begin expDone = 1; expTag = "R8"; end
      if (t == 0) begin
        expCmd = 4'b0010; expAddr = ADDR_W'(1024); expTag = "R5";
      end else if (t > 0 && t <= T_RP) begin
        expTag = "R6";
        if (t == T_RP) begin expCmd = 4'b0000; expBa = BA_W'(1); end
      end else if (t > T_RP && t <= T_RP + T_MRD) begin
        expTag = "R7";
        if (t == T_RP + T_MRD) begin expCmd = 4'b0000; expAddr = capWord; end
      end else if (t > T_RP + T_MRD && t < TOTAL) begin
        expTag = "R8";
      end
      if (expIll) expTag = "R3";
      if (expErr) expTag = "R4";
    end
  end

  logic [ADDR_W-1:0] lastMainAddr = '0;

  always @(negedge clk) begin
    if (!finished) begin
      cycles++;
      total++;
      if ({csN, rasN, casN, weN} !== expCmd || addr !== expAddr || bankAddr !== expBa ||
          busy !== expBusy || done !== expDone || illegalReq !== expIll || cfgError !== expErr) begin
        bad++;
        $display("FAIL %s cycle %0d: got cmd=%b addr=%h ba=%b busy=%b done=%b ill=%b err=%b exp cmd=%b addr=%h ba=%b busy=%b done=%b ill=%b err=%b",
                 expTag, cycles, {csN, rasN, casN, weN}, addr, bankAddr, busy, done, illegalReq, cfgError,
                 expCmd, expAddr, expBa, expBusy, expDone, expIll, expErr);
      end
      if ({csN, rasN, casN, weN} == 4'b0000 && bankAddr == '0) lastMainAddr = addr;
      if (cycles > WATCHDOG) begin
        total++; bad++;
        $display("FAIL watchdog: got cycles=%0d exp below %0d", cycles, WATCHDOG);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic request(input logic [NUM_BANKS-1:0] banks, input logic [2:0] bl,
                         input logic bt, input logic [2:0] cl, input logic dll);
    @(negedge clk);
    bankActive = banks; burstLenSel = bl; burstInterleave = bt; readLatSel = cl; dllReset = dll;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bankActive = '0;
  endtask

  task automatic checkWord(input string tag, input logic [ADDR_W-1:0] expw);
    total++;
    if (lastMainAddr !== expw) begin
      bad++;
      $display("FAIL %s: got main word=%h exp %h", tag, lastMainAddr, expw);
    end
  endtask

  initial begin
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(3);
    // R5 R6 R7 R8: normal run, burst 4, sequential, latency 3, DLL reset
    request('0, 3'b010, 1'b0, 3'b011, 1'b1);
    idle(TOTAL + 3);
    checkWord("R7", refWord(3'b010, 1'b0, 3'b011, 1'b1));
    // R3: open bank, also with bad settings (bank check first)
    request(4'b0100, 3'b010, 1'b0, 3'b011, 1'b0);
    idle(2);
    request(4'b0001, 3'b000, 1'b0, 3'b101, 1'b0);
    idle(2);
    // R4: unsupported codes
    request('0, 3'b000, 1'b0, 3'b010, 1'b0);
    idle(2);
    request('0, 3'b111, 1'b1, 3'b010, 1'b0);
    idle(2);
    request('0, 3'b011, 1'b0, 3'b100, 1'b0);
    idle(2);
    request('0, 3'b101, 1'b0, 3'b011, 1'b0);
    idle(2);
    // R10: full page with sequential burst
    request('0, 3'b111, 1'b0, 3'b010, 1'b0);
    idle(TOTAL + 3);
    checkWord("R10", refWord(3'b111, 1'b0, 3'b010, 1'b0));
    // R11: half-step latency code
    request('0, 3'b001, 1'b1, 3'b110, 1'b0);
    idle(TOTAL + 3);
    checkWord("R11", refWord(3'b001, 1'b1, 3'b110, 1'b0));
    // R9: inputs change and start pulses while busy
    request('0, 3'b001, 1'b1, 3'b010, 1'b0);
    request('0, 3'b011, 1'b0, 3'b011, 1'b1);
    request(4'b1111, 3'b000, 1'b0, 3'b000, 1'b1);
    idle(TOTAL + 3);
    checkWord("R9", refWord(3'b001, 1'b1, 3'b010, 1'b0));
    // Back-to-back: start held through the done cycle
    @(negedge clk);
    burstLenSel = 3'b011; burstInterleave = 1'b1; readLatSel = 3'b011; dllReset = 1'b0;
    start = 1'b1;
    idle(TOTAL + 2);
    start = 1'b0;
    idle(TOTAL + 3);
    checkWord("R7", refWord(3'b011, 1'b1, 3'b011, 1'b0));
    // R1: reset in the middle of a run
    request('0, 3'b010, 1'b0, 3'b010, 1'b0);
    idle(2);
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(4);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule